// File: doc/BRIEF.md
# Register-Programmed Single-Channel DMA Engine

This block copies a run of data from a source address to a destination address without processor involvement. Software loads a source pointer, a destination pointer, a byte count and a control word through a small register port, then sets the run bit. The engine alternates between a read master and a write master, moving one item at a time through a single-entry holding buffer. Each side can walk through memory or stay on one address to serve a peripheral data port.

A run ends in one of three ways, chosen by software: the byte count is used up, the source peripheral flags end-of-packet, or the destination peripheral flags end-of-packet. On completion a sticky done flag is set, and it can raise an interrupt. The item size can be 1, 2, 4, 8 or 16 bytes. The data bus is 128 bits wide by default. Data is carried lane-for-lane, and the write byte enables mark the bytes of the item at the destination offset.

Top module: `dma_engine`

## Requirements
- R1: After reset, all five registers read as zero, `irq` is 0, and neither `rd_valid` nor `wr_valid` is asserted.
- R2: A read is issued only while control bit 3 (run) is 1, the count is non-zero and the done flag is 0. With run at 0, or with done still set, nothing moves.
- R3: Each completed write lowers the count by the item size in bytes, saturating at zero. Each walking pointer advances by the item size.
- R4: When control bit 8 is 1 the source pointer stays fixed. When control bit 9 is 1 the destination pointer stays fixed.
- R5: The item size comes from control bits 0 (1 byte), 1 (2), 2 (4), 10 (8) and 11 (16). If several are set, the smallest wins. If none is set, the size is 1 byte. `wr_be` holds that many ones shifted up by the low four bits of the destination pointer.
- R6: With control bit 7 set, the write that brings the count to zero sets done and ends the run.
- R7: With control bit 7 clear, a count that reaches zero stops all movement but leaves done at 0.
- R8: With control bit 5 set, an item read while `rd_eop` is high is still written, and its write then ends the run with done. With bit 5 clear, `rd_eop` has no effect.
- R9: With control bit 6 set, a write accepted while `wr_eop` is high ends the run with done. With bit 6 clear, `wr_eop` has no effect.
- R10: Done stays set until any write to register 0, which clears it. `irq` equals control bit 4 AND done, delayed by one cycle.
- R11: Only one item is in flight: `rd_valid` and `wr_valid` are never both high. `wr_valid` and `wr_data` hold while `wr_ready` is low, and each write carries exactly the data of the preceding read.
- R12: Registers are indexed 0 status, 1 source, 2 destination, 3 count, 4 control. Status bit 0 is done and bit 1 is busy. `reg_rdata` shows the register selected by `reg_idx` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_idx` |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 32 | Read address |
| rd_ready | input | 1 | Read accepted; data is valid in the same cycle |
| rd_data | input | 128 | Read data |
| rd_eop | input | 1 | Source end-of-packet, sampled with the data |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | 32 | Write address |
| wr_data | output | 128 | Write data |
| wr_be | output | 16 | Write byte enables |
| wr_ready | input | 1 | Write accepted |
| wr_eop | input | 1 | Destination end-of-packet, sampled on acceptance |
| irq | output | 1 | Completion interrupt |

## Verification
The bench goes after a count that is not a multiple of the item size. A design that underflowed the count instead of saturating it would run on past the end. It also sets several size bits at once, to catch an engine that took the largest size or merged the sizes. End-of-packet is raised on both sides with its enable on and with it off, which exposes an engine that drops the flagged item or stops on a disabled flag. Further runs cover a count reaching zero with the length stop disabled, a done flag that is left set while the run bit stays on, and a destination that stalls. These expose, in turn, an engine that reports done when it should only stop, one that restarts without being cleared, and one that lets a held write change or overlap a read.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WRITE = 2'd2
  } xfer_st_e;

  // register indices
  localparam int RI_STATUS = 0;
  localparam int RI_RADDR  = 1;
  localparam int RI_WADDR  = 2;
  localparam int RI_LEN    = 3;
  localparam int RI_CTRL   = 4;

  // control bit positions
  localparam int CB_BYTE  = 0;
  localparam int CB_HALF  = 1;
  localparam int CB_WORD  = 2;
  localparam int CB_GO    = 3;
  localparam int CB_IEN   = 4;
  localparam int CB_REOP  = 5;
  localparam int CB_WEOP  = 6;
  localparam int CB_LEND  = 7;
  localparam int CB_RFIX  = 8;
  localparam int CB_WFIX  = 9;
  localparam int CB_DWORD = 10;
  localparam int CB_QWORD = 11;

  localparam int SZW = 5;

  // smallest selected size wins; no size bit means one byte
  function automatic logic [SZW-1:0] pick_size(input logic [11:0] c);
    if (c[CB_BYTE])       return SZW'(1);
    else if (c[CB_HALF])  return SZW'(2);
    else if (c[CB_WORD])  return SZW'(4);
    else if (c[CB_DWORD]) return SZW'(8);
    else if (c[CB_QWORD]) return SZW'(16);
    else                  return SZW'(1);
  endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 32,
  parameter int RW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sw_we,
  input  logic [2:0]     sw_idx,
  input  logic [RW-1:0]  sw_wdata,
  output logic [RW-1:0]  sw_rdata,
  input  logic           busy,
  input  logic           step,
  input  logic           term,
  output logic           go,
  output logic           ien,
  output logic           reen,
  output logic           ween,
  output logic           leen,
  output logic           done,
  output logic           len_zero,
  output logic           len_after_zero,
  output logic [AW-1:0]  raddr,
  output logic [AW-1:0]  waddr,
  output logic [SZW-1:0] size_b,
  output logic           irq
);

  logic [RW-1:0] ctrl_q;
  logic [AW-1:0] raddr_q, waddr_q;
  logic [LW-1:0] len_q, len_after, sz_len;
  logic          done_q, irq_q;

  logic wr_status, wr_raddr, wr_len;
  assign wr_status = sw_we && (sw_idx == 3'(RI_STATUS));
  assign wr_raddr  = sw_we && (sw_idx == 3'(RI_RADDR));
  assign wr_len    = sw_we && (sw_idx == 3'(RI_LEN));

  assign size_b    = pick_size(ctrl_q[11:0]);
  assign sz_len    = LW'(size_b);
  assign len_after = (len_q > sz_len) ? (len_q - sz_len) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      raddr_q  <= '0;
      waddr_q  <= '0;
      len_q    <= '0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
      sw_rdata <= '0;
    end else begin
      if (step) begin
        if (!ctrl_q[CB_RFIX]) raddr_q <= raddr_q + AW'(size_b);
        if (!ctrl_q[CB_WFIX]) waddr_q <= waddr_q + AW'(size_b);
        len_q <= len_after;
      end
      // software writes take priority over the engine's update
      if (sw_we) begin
        case (sw_idx)
          3'(RI_STATUS): done_q  <= 1'b0;
          3'(RI_RADDR):  raddr_q <= AW'(sw_wdata);
          3'(RI_WADDR):  waddr_q <= AW'(sw_wdata);
          3'(RI_LEN):    len_q   <= LW'(sw_wdata);
          3'(RI_CTRL):   ctrl_q  <= sw_wdata;
          default: ;
        endcase
      end
      if (term) done_q <= 1'b1;
      irq_q <= ctrl_q[CB_IEN] & done_q;
      case (sw_idx)
        3'(RI_STATUS): sw_rdata <= RW'({busy, done_q});
        3'(RI_RADDR):  sw_rdata <= RW'(raddr_q);
        3'(RI_WADDR):  sw_rdata <= RW'(waddr_q);
        3'(RI_LEN):    sw_rdata <= RW'(len_q);
        3'(RI_CTRL):   sw_rdata <= ctrl_q;
        default:       sw_rdata <= '0;
      endcase
    end
  end

  assign go             = ctrl_q[CB_GO];
  assign ien            = ctrl_q[CB_IEN];
  assign reen           = ctrl_q[CB_REOP];
  assign ween           = ctrl_q[CB_WEOP];
  assign leen           = ctrl_q[CB_LEND];
  assign done           = done_q;
  assign len_zero       = (len_q == '0);
  assign len_after_zero = (len_after == '0);
  assign raddr          = raddr_q;
  assign waddr          = waddr_q;
  assign irq            = irq_q;

  p_rfix_hold_r4: assert property (@(posedge clk) disable iff (rst)
    step && ctrl_q[CB_RFIX] && !wr_raddr |=> $stable(raddr_q));

  p_len_shrinks_r3: assert property (@(posedge clk) disable iff (rst)
    step && !wr_len |=> len_q < $past(len_q));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    done_q && !wr_status |=> done_q);

  p_irq_drops_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(done_q) |=> !irq_q);

endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
  import dma_pkg::*;
#(
  parameter int DW = 128,
  localparam int BEW = DW / 8,
  localparam int OB = $clog2(BEW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           done,
  input  logic           len_zero,
  input  logic           len_after_zero,
  input  logic           reen,
  input  logic           ween,
  input  logic           leen,
  input  logic [SZW-1:0] size_b,
  input  logic [OB-1:0]  wofs,
  output logic           rd_valid,
  input  logic           rd_ready,
  input  logic [DW-1:0]  rd_data,
  input  logic           rd_eop,
  output logic           wr_valid,
  output logic [DW-1:0]  wr_data,
  output logic [BEW-1:0] wr_be,
  input  logic           wr_ready,
  input  logic           wr_eop,
  output logic           step,
  output logic           term,
  output logic           busy
);

  xfer_st_e        st_q;
  logic [DW-1:0]   buf_q;
  logic            eop_q;
  logic            start;
  logic [2*BEW-1:0] mask;

  assign start = (st_q == XS_IDLE) && go && !len_zero && !done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= XS_IDLE;
      buf_q <= '0;
      eop_q <= 1'b0;
    end else begin
      case (st_q)
        XS_IDLE:  if (start) st_q <= XS_READ;
        XS_READ:  if (rd_ready) begin
                    buf_q <= rd_data;
                    eop_q <= rd_eop;
                    st_q  <= XS_WRITE;
                  end
        XS_WRITE: if (wr_ready) st_q <= XS_IDLE;
        default:  st_q <= XS_IDLE;
      endcase
    end
  end

  assign rd_valid = (st_q == XS_READ);
  assign wr_valid = (st_q == XS_WRITE);
  assign wr_data  = buf_q;
  assign busy     = (st_q != XS_IDLE);
  assign step     = wr_valid && wr_ready;
  assign term     = step && ((leen && len_after_zero) || (reen && eop_q) || (ween && wr_eop));

  assign mask  = ((2*BEW)'(1) << size_b) - (2*BEW)'(1);
  assign wr_be = BEW'(mask << wofs);

  p_go_gate_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> $past(go && !len_zero && !done));

  p_one_phase_r11: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_valid));

  p_wr_hold_r11: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));

  p_term_stops_r6: assert property (@(posedge clk) disable iff (rst)
    term |=> !busy);

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 32,
  parameter int RW = 32,
  parameter int DW = 128,
  localparam int BEW = DW / 8,
  localparam int OB = $clog2(BEW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [2:0]     reg_idx,
  input  logic [RW-1:0]  reg_wdata,
  output logic [RW-1:0]  reg_rdata,
  output logic           rd_valid,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_ready,
  input  logic [DW-1:0]  rd_data,
  input  logic           rd_eop,
  output logic           wr_valid,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic [BEW-1:0] wr_be,
  input  logic           wr_ready,
  input  logic           wr_eop,
  output logic           irq
);

  logic go, ien, reen, ween, leen, done, len_zero, len_after_zero;
  logic step, term, busy;
  logic [SZW-1:0] size_b;
  logic [AW-1:0]  raddr, waddr;

  dma_regs #(.AW(AW), .LW(LW), .RW(RW)) u_regs (
    .clk(clk), .rst(rst),
    .sw_we(reg_we), .sw_idx(reg_idx), .sw_wdata(reg_wdata), .sw_rdata(reg_rdata),
    .busy(busy), .step(step), .term(term),
    .go(go), .ien(ien), .reen(reen), .ween(ween), .leen(leen), .done(done),
    .len_zero(len_zero), .len_after_zero(len_after_zero),
    .raddr(raddr), .waddr(waddr), .size_b(size_b), .irq(irq)
  );

  dma_xfer #(.DW(DW)) u_xfer (
    .clk(clk), .rst(rst),
    .go(go), .done(done), .len_zero(len_zero), .len_after_zero(len_after_zero),
    .reen(reen), .ween(ween), .leen(leen), .size_b(size_b), .wofs(waddr[OB-1:0]),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_eop(rd_eop),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_be(wr_be),
    .wr_ready(wr_ready), .wr_eop(wr_eop),
    .step(step), .term(term), .busy(busy)
  );

  assign rd_addr = raddr;
  assign wr_addr = waddr;

  p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ien));

endmodule

// File: tb/tb_dma_engine.sv
`timescale 1ns/1ps
module tb_dma_engine;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_idx = 3'd0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         rd_valid, wr_valid, irq;
  logic [31:0]  rd_addr, wr_addr;
  logic         rd_ready = 1'b1;
  logic [127:0] rd_data, wr_data;
  logic         rd_eop, wr_eop;
  logic [15:0]  wr_be;
  logic         wr_ready = 1'b1;
  logic [31:0]  reop_at = 32'hFFFF_FFFF;
  logic [31:0]  weop_at = 32'hFFFF_FFFF;

  always #2.5 clk = ~clk;

  assign rd_data = {4{rd_addr}};
  assign rd_eop  = (rd_addr == reop_at);
  assign wr_eop  = (wr_addr == weop_at);

  dma_engine dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_eop(rd_eop), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .wr_ready(wr_ready), .wr_eop(wr_eop), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  int wcount = 0;
  int data_err = 0;
  int ovl_err = 0;
  logic [31:0] last_ra = '0;
  logic [15:0] first_be = '0;

  // port monitor
  always @(negedge clk) begin
    if (rd_valid && wr_valid) ovl_err++;
    if (rd_valid && rd_ready) last_ra = rd_addr;
    if (wr_valid && wr_ready) begin
      if (wcount == 0) first_be = wr_be;
      if (wr_data !== {4{last_ra}}) data_err++;
      wcount++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input int idx, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 3'(idx); reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input int idx, output logic [31:0] v);
    @(negedge clk);
    reg_idx = 3'(idx);
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] ctrl, ra, wa, len, reop, weop, n, era, ewa, elen, edone, ebe;
  } vec_t;

  localparam logic [31:0] NO = 32'hFFFF_FFFF;
  // ctrl bits: 0 byte, 1 half, 2 word, 3 run, 4 irq en, 5 src eop, 6 dst eop,
  // 7 length stop, 8 src fixed, 9 dst fixed, 10 dword, 11 qword
  localparam vec_t VEC [0:12] = '{
    '{32'h08C, 32'h100, 32'h200, 32'd16, NO, NO, 32'd4, 32'h110, 32'h210, 32'd0, 32'd1, 32'h000F},
    '{32'h189, 32'h040, 32'h080, 32'd3,  NO, NO, 32'd3, 32'h040, 32'h083, 32'd0, 32'd1, 32'h0001},
    '{32'h28A, 32'h010, 32'h030, 32'd8,  NO, NO, 32'd4, 32'h018, 32'h030, 32'd0, 32'd1, 32'h0003},
    '{32'h488, 32'h000, 32'h208, 32'd16, NO, NO, 32'd2, 32'h010, 32'h218, 32'd0, 32'd1, 32'hFF00},
    '{32'h888, 32'h1000, 32'h300, 32'd32, NO, NO, 32'd2, 32'h1020, 32'h320, 32'd0, 32'd1, 32'hFFFF},
    '{32'h08E, 32'h020, 32'h042, 32'd4,  NO, NO, 32'd2, 32'h024, 32'h046, 32'd0, 32'd1, 32'h000C},
    '{32'h088, 32'h050, 32'h061, 32'd2,  NO, NO, 32'd2, 32'h052, 32'h063, 32'd0, 32'd1, 32'h0002},
    '{32'h08C, 32'h100, 32'h200, 32'd5,  NO, NO, 32'd2, 32'h108, 32'h208, 32'd0, 32'd1, 32'h000F},
    '{32'h00C, 32'h100, 32'h200, 32'd8,  NO, NO, 32'd2, 32'h108, 32'h208, 32'd0, 32'd0, 32'h000F},
    '{32'h084, 32'h100, 32'h200, 32'd8,  NO, NO, 32'd0, 32'h100, 32'h200, 32'd8, 32'd0, 32'h0000},
    '{32'h02C, 32'h100, 32'h200, 32'd64, 32'h108, NO, 32'd3, 32'h10C, 32'h20C, 32'd52, 32'd1, 32'h000F},
    '{32'h04C, 32'h100, 32'h200, 32'd64, NO, 32'h204, 32'd2, 32'h108, 32'h208, 32'd56, 32'd1, 32'h000F},
    '{32'h08C, 32'h100, 32'h200, 32'd16, 32'h104, 32'h204, 32'd4, 32'h110, 32'h210, 32'd0, 32'd1, 32'h000F}
  };

  task automatic prime(input logic [31:0] ra, input logic [31:0] wa, input logic [31:0] len);
    wreg(4, 32'h0);
    wreg(0, 32'h0);
    wcount = 0;
    wreg(1, ra);
    wreg(2, wa);
    wreg(3, len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 / R12: reset state of every register and output
    for (int i = 0; i < 5; i++) begin
      rreg(i, v);
      check("R1 register reset", v, 32'h0);
    end
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    check("R1 idle masters", {30'b0, rd_valid, wr_valid}, 32'h0);

    // table of runs
    for (int k = 0; k < 13; k++) begin
      prime(VEC[k].ra, VEC[k].wa, VEC[k].len);
      reop_at = VEC[k].reop;
      weop_at = VEC[k].weop;
      wreg(4, VEC[k].ctrl);
      idle(120);
      check($sformatf("R3 R6 R7 R8 R9 vec%0d writes", k), wcount, VEC[k].n);
      rreg(1, v); check($sformatf("R3 R4 vec%0d src", k), v, VEC[k].era);
      rreg(2, v); check($sformatf("R3 R4 vec%0d dst", k), v, VEC[k].ewa);
      rreg(3, v); check($sformatf("R3 R7 vec%0d count", k), v, VEC[k].elen);
      rreg(0, v); check($sformatf("R6 R7 R12 vec%0d status", k), v, VEC[k].edone);
      if (VEC[k].n != 0) check($sformatf("R5 vec%0d byte enables", k), {16'b0, first_be}, VEC[k].ebe);
      reop_at = NO;
      weop_at = NO;
    end

    // R10: interrupt follows done with enable set, clears on status write
    prime(32'h100, 32'h200, 32'd4);
    wreg(4, 32'h09C);
    idle(30);
    check("R10 irq raised", {31'b0, irq}, 32'h1);
    rreg(0, v); check("R12 status done only", v, 32'h1);
    wreg(0, 32'h0);
    idle(3);
    check("R10 irq cleared", {31'b0, irq}, 32'h0);
    rreg(0, v); check("R10 done cleared", v, 32'h0);

    // R10: no interrupt without enable
    prime(32'h100, 32'h200, 32'd4);
    wreg(4, 32'h08C);
    idle(30);
    rreg(0, v); check("R10 done set", v, 32'h1);
    check("R10 irq masked", {31'b0, irq}, 32'h0);

    // R2: pending done blocks a restart even with run still on
    wcount = 0;
    wreg(3, 32'd8);
    idle(30);
    check("R2 no restart while done", wcount, 32'd0);
    wreg(0, 32'h0);
    idle(30);
    check("R2 resumes after clear", wcount, 32'd2);

    // R11: destination stall holds the write and keeps the read idle
    prime(32'h100, 32'h200, 32'd4);
    wr_ready = 1'b0;
    wreg(4, 32'h08C);
    idle(20);
    check("R11 write held", {30'b0, rd_valid, wr_valid}, 32'h1);
    rreg(0, v); check("R12 status busy", v, 32'h2);
    check("R11 nothing accepted", wcount, 32'd0);
    wr_ready = 1'b1;
    idle(20);
    check("R11 single write after stall", wcount, 32'd1);
    rreg(0, v); check("R6 done after stall", v, 32'h1);

    check("R11 write data matches read", data_err, 32'd0);
    check("R11 no read/write overlap", ovl_err, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule